// File: doc/BRIEF.md
# Rename Map Table with Result Snoop

This block is the register rename map of an out-of-order core. It keeps one entry per architectural register. Each entry holds a data value, a ready flag and the tag of the in-flight operation that will write the register next. Each cycle the front end presents one instruction with two source registers and an optional destination.

For each source, the block returns either a ready value or the producer tag that the consumer has to wait for. For the destination, it records the freshly allocated tag and marks the register as pending.

The block also snoops a result broadcast bus. A pending register whose stored tag equals the broadcast tag captures the broadcast value and becomes ready again. If the register was renamed again in the meantime, its stored tag has moved on, so a stale result can no longer land in it.

Tag allocation, the waiting stations and recovery checkpoints live elsewhere.

Top module: `rename_map`

## Requirements
- R1: After reset every register is ready and holds value 0, so every source lookup returns ready=1, value 0 and tag 0.
- R2: A lookup of a ready register returns ready=1, its stored value, and tag 0.
- R3: A lookup of a pending register with no matching broadcast in the same cycle returns ready=0, value 0 and the stored producer tag.
- R4: A rename with `ren_valid_i`=1 and `dst_en_i`=1 stores `dst_tag_i` in register `dst_idx_i` and marks it pending from the next cycle on.
- R5: A broadcast writes `bc_value_i` into every pending register whose stored tag equals `bc_tag_i` and marks it ready from the next cycle on. Registers that are already ready are not touched.
- R6: A register renamed a second time ignores a later broadcast of its first producer's tag and stays pending on the second tag.
- R7: A lookup of a pending register whose stored tag matches a broadcast in the same cycle returns ready=1 with the broadcast value.
- R8: A rename and a matching broadcast to the same register in the same cycle leave the register pending on the new tag.
- R9: A cycle with `ren_valid_i`=0 or `dst_en_i`=0 and no broadcast changes no register.
- R10: A lookup of a register that is also the destination in the same cycle returns the contents held before that rename.
- R11: One broadcast completes all pending registers that hold its tag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | An instruction is presented for renaming |
| src_a_idx_i | input | IDX_W | First source register index |
| src_b_idx_i | input | IDX_W | Second source register index |
| dst_en_i | input | 1 | The instruction writes a destination register |
| dst_idx_i | input | IDX_W | Destination register index |
| dst_tag_i | input | TAG_W | Tag allocated to the destination's producer |
| src_a_ready_o | output | 1 | First source value is available |
| src_a_value_o | output | DATA_W | First source value (0 when pending) |
| src_a_tag_o | output | TAG_W | First source producer tag (0 when ready) |
| src_b_ready_o | output | 1 | Second source value is available |
| src_b_value_o | output | DATA_W | Second source value (0 when pending) |
| src_b_tag_o | output | TAG_W | Second source producer tag (0 when ready) |
| bc_valid_i | input | 1 | A result is on the broadcast bus |
| bc_tag_i | input | TAG_W | Tag of the broadcast producer |
| bc_value_i | input | DATA_W | Broadcast result value |

## Verification
The bench builds the block with ten registers, 32-bit values and 3-bit tags, which are the default values. With only eight tags, a random stream reuses tags quickly. This brings within reach several registers pending on one tag, stale broadcasts after a second rename, and broadcasts that arrive in the same cycle as a rename or a lookup of the same register. Index codes above nine are never driven, so the behaviour for out-of-range indices is left unexercised.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;
    localparam int DEF_NUM_REGS = 10;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_TAG_W    = 3;
endpackage

// File: rtl/rename_map_entry.sv
module rename_map_entry #(
    parameter int DATA_W = rename_map_pkg::DEF_DATA_W,
    parameter int TAG_W  = rename_map_pkg::DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rename_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    localparam entry_t RESET_ENTRY = '{valid: 1'b1, tag: '0, value: '0};

    entry_t st_d, st_q;

    // A new rename has priority over a result for the previous producer.
    always_comb begin
        st_d = st_q;
        if (wr_rename_i) begin
            st_d.tag   = wr_tag_i;
            st_d.valid = 1'b0;
        end else if (bc_valid_i && !st_q.valid && (st_q.tag == bc_tag_i)) begin
            st_d.value = bc_value_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ENTRY;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign tag_o   = st_q.tag;
    assign value_o = st_q.value;
endmodule

// File: rtl/rename_map_lookup.sv
module rename_map_lookup #(
    parameter int NUM_REGS = rename_map_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rename_map_pkg::DEF_DATA_W,
    parameter int TAG_W    = rename_map_pkg::DEF_TAG_W,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [NUM_REGS-1:0] valid_vec_i,
    input  logic [TAG_W-1:0]  tag_arr_i   [NUM_REGS],
    input  logic [DATA_W-1:0] value_arr_i [NUM_REGS],
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] value_o,
    output logic [TAG_W-1:0]  tag_o
);
    always_comb begin
        ready_o = 1'b1;
        value_o = '0;
        tag_o   = '0;
        if (int'(idx_i) < NUM_REGS) begin
            if (valid_vec_i[idx_i]) begin
                value_o = value_arr_i[idx_i];
            end else if (bc_valid_i && (tag_arr_i[idx_i] == bc_tag_i)) begin
                value_o = bc_value_i;
            end else begin
                ready_o = 1'b0;
                tag_o   = tag_arr_i[idx_i];
            end
        end
    end
endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int NUM_REGS = rename_map_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rename_map_pkg::DEF_DATA_W,
    parameter int TAG_W    = rename_map_pkg::DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid_i,
    input  logic [IDX_W-1:0]  src_a_idx_i,
    input  logic [IDX_W-1:0]  src_b_idx_i,
    input  logic              dst_en_i,
    input  logic [IDX_W-1:0]  dst_idx_i,
    input  logic [TAG_W-1:0]  dst_tag_i,
    output logic              src_a_ready_o,
    output logic [DATA_W-1:0] src_a_value_o,
    output logic [TAG_W-1:0]  src_a_tag_o,
    output logic              src_b_ready_o,
    output logic [DATA_W-1:0] src_b_value_o,
    output logic [TAG_W-1:0]  src_b_tag_o,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i
);
    logic [NUM_REGS-1:0] valid_vec;
    logic [TAG_W-1:0]    tag_arr   [NUM_REGS];
    logic [DATA_W-1:0]   value_arr [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
        logic wr_rename;
        assign wr_rename = ren_valid_i && dst_en_i && (dst_idx_i == IDX_W'(k));

        rename_map_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_rename_i (wr_rename),
            .wr_tag_i    (dst_tag_i),
            .bc_valid_i  (bc_valid_i),
            .bc_tag_i    (bc_tag_i),
            .bc_value_i  (bc_value_i),
            .valid_o     (valid_vec[k]),
            .tag_o       (tag_arr[k]),
            .value_o     (value_arr[k])
        );
    end

    rename_map_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W)
    ) u_look_a (
        .idx_i       (src_a_idx_i),
        .valid_vec_i (valid_vec),
        .tag_arr_i   (tag_arr),
        .value_arr_i (value_arr),
        .bc_valid_i  (bc_valid_i),
        .bc_tag_i    (bc_tag_i),
        .bc_value_i  (bc_value_i),
        .ready_o     (src_a_ready_o),
        .value_o     (src_a_value_o),
        .tag_o       (src_a_tag_o)
    );

    rename_map_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W)
    ) u_look_b (
        .idx_i       (src_b_idx_i),
        .valid_vec_i (valid_vec),
        .tag_arr_i   (tag_arr),
        .value_arr_i (value_arr),
        .bc_valid_i  (bc_valid_i),
        .bc_tag_i    (bc_tag_i),
        .bc_value_i  (bc_value_i),
        .ready_o     (src_b_ready_o),
        .value_o     (src_b_value_o),
        .tag_o       (src_b_tag_o)
    );
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
    parameter int NUM_REGS = rename_map_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rename_map_pkg::DEF_DATA_W,
    parameter int TAG_W    = rename_map_pkg::DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ren_valid_i,
    input logic                dst_en_i,
    input logic [IDX_W-1:0]    dst_idx_i,
    input logic [TAG_W-1:0]    dst_tag_i,
    input logic [IDX_W-1:0]    src_a_idx_i,
    input logic                src_a_ready_o,
    input logic [TAG_W-1:0]    src_a_tag_o,
    input logic                bc_valid_i,
    input logic [TAG_W-1:0]    bc_tag_i,
    input logic [DATA_W-1:0]   bc_value_i,
    input logic [NUM_REGS-1:0] valid_vec,
    input logic [TAG_W-1:0]    tag_arr   [NUM_REGS],
    input logic [DATA_W-1:0]   value_arr [NUM_REGS]
);
    // R1: the first cycle out of reset sees every register ready
    p_reset_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&valid_vec));

    // R3: a pending source with no matching broadcast reports its tag
    p_pending_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(src_a_idx_i) < NUM_REGS) && !valid_vec[src_a_idx_i] &&
         !(bc_valid_i && (bc_tag_i == tag_arr[src_a_idx_i])))
        |-> (!src_a_ready_o && (src_a_tag_o == tag_arr[src_a_idx_i])));

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        // R4: a rename leaves the register pending on the new tag
        p_rename_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid_i && dst_en_i && (dst_idx_i == IDX_W'(k)))
            |=> (!valid_vec[k] && (tag_arr[k] == $past(dst_tag_i))));

        // R5: a matching broadcast completes a pending register
        p_bcast_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid_i && !valid_vec[k] && (tag_arr[k] == bc_tag_i) &&
             !(ren_valid_i && dst_en_i && (dst_idx_i == IDX_W'(k))))
            |=> (valid_vec[k] && (value_arr[k] == $past(bc_value_i))));

        // R8: a rename beats a same-cycle broadcast
        p_rename_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid_i && dst_en_i && (dst_idx_i == IDX_W'(k)) && bc_valid_i &&
             (tag_arr[k] == bc_tag_i))
            |=> !valid_vec[k]);

        // R9: with no write source active the register holds
        p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ren_valid_i && dst_en_i) && !bc_valid_i)
            |=> ($stable(valid_vec[k]) && $stable(tag_arr[k]) && $stable(value_arr[k])));
    end
endmodule

bind rename_map rename_map_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
) u_chk (.*);

// File: tb/rename_map_tb.sv
module rename_map_tb;
    localparam int NREG  = 10;
    localparam int DW    = 32;
    localparam int TW    = 3;
    localparam int IW    = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [IW-1:0] src_a = '0;
    logic [IW-1:0] src_b = '0;
    logic          dst_en = 1'b0;
    logic [IW-1:0] dst_idx = '0;
    logic [TW-1:0] dst_tag = '0;
    logic          a_rdy, b_rdy;
    logic [DW-1:0] a_val, b_val;
    logic [TW-1:0] a_tag, b_tag;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_value = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    bit          m_valid [NREG];
    int          m_tag   [NREG];
    logic [DW-1:0] m_val [NREG];

    always #10 clk = ~clk;

    rename_map #(.NUM_REGS(NREG), .DATA_W(DW), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ren_valid_i(ren_valid),
        .src_a_idx_i(src_a), .src_b_idx_i(src_b),
        .dst_en_i(dst_en), .dst_idx_i(dst_idx), .dst_tag_i(dst_tag),
        .src_a_ready_o(a_rdy), .src_a_value_o(a_val), .src_a_tag_o(a_tag),
        .src_b_ready_o(b_rdy), .src_b_value_o(b_val), .src_b_tag_o(b_tag),
        .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_value_i(bc_value)
    );

    task automatic check_src(input string scen, input string port, input int idx,
                             input logic rdy, input logic [DW-1:0] val, input logic [TW-1:0] tg);
        logic          e_rdy;
        logic [DW-1:0] e_val;
        logic [TW-1:0] e_tag;
        string         req;
        if (m_valid[idx]) begin
            e_rdy = 1'b1; e_val = m_val[idx]; e_tag = '0; req = "R2";
        end else if (bc_valid && (int'(bc_tag) == m_tag[idx])) begin
            e_rdy = 1'b1; e_val = bc_value; e_tag = '0; req = "R7";
        end else begin
            e_rdy = 1'b0; e_val = '0; e_tag = TW'(m_tag[idx]); req = "R3";
        end
        checks++;
        if (rdy !== e_rdy || val !== e_val || tg !== e_tag) begin
            errors++;
            $display("FAIL %s/%s %s reg %0d: got rdy=%0b val=%h tag=%0d exp rdy=%0b val=%h tag=%0d",
                     scen, req, port, idx, rdy, val, tg, e_rdy, e_val, e_tag);
        end
    endtask

    task automatic model_clock();
        bit ren;
        ren = ren_valid && dst_en;
        for (int k = 0; k < NREG; k++) begin
            if (ren && int'(dst_idx) == k) begin
                m_tag[k] = int'(dst_tag);
                m_valid[k] = 1'b0;
            end else if (bc_valid && !m_valid[k] && m_tag[k] == int'(bc_tag)) begin
                m_val[k] = bc_value;
                m_valid[k] = 1'b1;
            end
        end
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic cycle(input string scen);
        #1;
        check_src(scen, "a", int'(src_a), a_rdy, a_val, a_tag);
        check_src(scen, "b", int'(src_b), b_rdy, b_val, b_tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        ren_valid = 1'b0;
        dst_en    = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic look(input int a, input int b);
        src_a = IW'(a);
        src_b = IW'(b);
    endtask

    task automatic ren(input int d, input int t);
        ren_valid = 1'b1;
        dst_en    = 1'b1;
        dst_idx   = IW'(d);
        dst_tag   = TW'(t);
    endtask

    task automatic bcast(input int t, input logic [DW-1:0] v);
        bc_valid = 1'b1;
        bc_tag   = TW'(t);
        bc_value = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got no end exp end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NREG; k++) begin
            m_valid[k] = 1'b1; m_tag[k] = 0; m_val[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents of every register
        for (int k = 0; k < NREG; k += 2) begin
            look(k, k + 1);
            cycle("R1");
        end

        // R4 then R3: rename r3 to tag 5, then look it up
        look(3, 0); ren(3, 5); cycle("R10");
        look(3, 4); cycle("R4");

        // R7 and R5: broadcast tag 5 while r3 is looked up, then read it again
        look(3, 3); bcast(5, 32'hCAFE_0005); cycle("R7");
        look(3, 2); cycle("R5");

        // R6: r1 renamed twice, first producer's result must not land
        ren(1, 2); look(1, 1); cycle("R4");
        ren(1, 4); look(1, 0); cycle("R6");
        bcast(2, 32'hDEAD_0002); look(1, 1); cycle("R6");
        look(1, 0); cycle("R6");
        bcast(4, 32'h0000_1234); look(0, 1); cycle("R5");
        look(1, 1); cycle("R6");

        // R8: rename and matching broadcast to r2 in one cycle
        ren(2, 1); look(2, 0); cycle("R4");
        ren(2, 3); bcast(1, 32'h1111_0001); look(5, 6); cycle("R8");
        look(2, 2); cycle("R8");

        // R9: destination disabled, and a rename without ren_valid
        ren_valid = 1'b1; dst_en = 1'b0; dst_idx = 0; dst_tag = 7; look(0, 0); cycle("R9");
        look(0, 0); cycle("R9");
        ren_valid = 1'b0; dst_en = 1'b1; dst_idx = 4; dst_tag = 6; look(4, 4); cycle("R9");
        look(4, 0); cycle("R9");

        // R10: look up the register being renamed in the same cycle
        look(3, 3); ren(3, 0); cycle("R10");
        look(3, 0); cycle("R10");

        // R11: two registers pending on one tag complete together
        ren(5, 6); cycle("R11");
        ren(6, 6); cycle("R11");
        look(5, 6); cycle("R11");
        bcast(6, 32'h6666_0006); look(7, 8); cycle("R11");
        look(5, 6); cycle("R11");

        // mixed random traffic against the reference model
        for (int n = 0; n < 600; n++) begin
            look($urandom_range(NREG - 1), $urandom_range(NREG - 1));
            if ($urandom_range(3) != 0) begin
                ren_valid = 1'b1;
                dst_en    = ($urandom_range(4) != 0);
                dst_idx   = IW'($urandom_range(NREG - 1));
                dst_tag   = TW'($urandom_range(7));
            end
            if ($urandom_range(1) == 1) begin
                bcast(m_tag[$urandom_range(NREG - 1)], DW'($urandom));
            end
            cycle("R5");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule